// File: doc/BRIEF.md
# Time Base and Decrementer Unit

This block keeps a free-running 64-bit time base and one or two 32-bit down-counters. All of them move only on cycles where the shared tick enable is high. The time base advances by one per tick while its run input is high. It holds its value while run is low, and it continues from that value when run returns. Software can rewrite either 32-bit half of the time base on its own. It can also rewrite a restricted legacy real-time-clock view of the lower word, in which only the bits of mask 0x3FFFFF80 are significant.

The main decrementer and the optional hypervisor decrementer count down once per tick, whatever the time-base run input is doing. Each one raises its own exception request in two cases: when it steps past zero, where it wraps to all-ones and keeps counting, and when software writes a value whose sign bit is set over a count whose sign bit is clear. A request stays high until its acknowledge input clears it. After reset the time base is zero, both counters hold all-ones and no request is pending.

The counter values are presented continuously as read ports. Writes use a single shared data bus with a separate strobe for each target.

Top module: `tbdec_unit`

## Requirements
- R1: After reset, tb_hi and tb_lo are 0, dec_val and hdec_val are 0xFFFFFFFF, and dec_irq and hdec_irq are low.
- R2: While tb_run and tick_en are high and no time-base write occurs, {tb_hi,tb_lo} increases by one per cycle. A carry out of tb_lo reaches tb_hi in the same cycle.
- R3: While tb_run is low, the time base holds its value. When tb_run returns high, counting resumes from the held value.
- R4: tbl_wr loads wr_data into tb_lo and leaves tb_hi unchanged. tbu_wr loads wr_data into tb_hi and leaves tb_lo unchanged. A cycle with any time-base write does not also increment.
- R5: dec_val decreases by one on each tick_en cycle, independent of tb_run.
- R6: A tick while dec_val is 0 loads 0xFFFFFFFF and sets dec_irq at the same edge.
- R7: dec_wr sets dec_irq only when wr_data bit 31 is 1 and the current dec_val bit 31 is 0. Any other write leaves dec_irq unchanged.
- R8: A dec_wr in a tick cycle loads wr_data and suppresses that cycle's decrement and expiry.
- R9: dec_irq stays high until dec_ack is high at a clock edge. If a new exception is raised at the same edge as dec_ack, the raise wins.
- R10: hdec_val and hdec_irq follow R5 to R9 with hdec_wr and hdec_ack, independently of the main decrementer. When parameter HDEC_ON is 0, both read 0.
- R11: rtc_lo equals tb_lo AND 0x3FFFFF80. rtc_wr loads tb_lo with wr_data AND 0x3FFFFF80, leaves tb_hi unchanged, and loses to tbl_wr in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Common count tick |
| tb_run | input | 1 | Time-base run (high) / freeze (low) |
| tbl_wr | input | 1 | Write lower time-base word |
| tbu_wr | input | 1 | Write upper time-base word |
| rtc_wr | input | 1 | Write masked real-time-clock lower view |
| dec_wr | input | 1 | Write main decrementer |
| hdec_wr | input | 1 | Write hypervisor decrementer |
| wr_data | input | 32 | Shared write data |
| dec_ack | input | 1 | Clear main decrementer request |
| hdec_ack | input | 1 | Clear hypervisor decrementer request |
| tb_lo | output | 32 | Time base lower word |
| tb_hi | output | 32 | Time base upper word |
| rtc_lo | output | 32 | Masked lower-word view |
| dec_val | output | 32 | Main decrementer count |
| hdec_val | output | 32 | Hypervisor decrementer count |
| dec_irq | output | 1 | Main decrementer exception request |
| hdec_irq | output | 1 | Hypervisor decrementer exception request |

## Verification
A directed sequence drives several patterns:
- Steady ticking, a lower word of all-ones, and a freeze window. These separate a correct carry into the upper half from a one-cycle-late carry, and a frozen time base from a frozen decrementer.
- Decrementer writes that pair each sign combination of old and new value. These show that only a non-negative to negative change raises a request.
- Writes and acknowledges landing in the same cycle as a tick or an expiry. These pin down the priority rules.
- A long stretch of random ticks, freezes, small reloads and acknowledges, compared every cycle against a behavioural model. This reaches wraps on both decrementers and overlaps between their requests.

// File: rtl/tbdec_pkg.sv
package tbdec_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam logic [WORD_W-1:0] RTC_MASK_DEF = 32'h3FFF_FF80;
endpackage

// File: rtl/tbdec_rst_sync.sv
module tbdec_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/tbdec_base.sv
module tbdec_base #(
  parameter int unsigned HALF_W = 32,
  parameter logic [HALF_W-1:0] RTC_MASK = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              run,
  input  logic              lo_wr,
  input  logic              hi_wr,
  input  logic              rtc_wr,
  input  logic [HALF_W-1:0] wdata,
  output logic [HALF_W-1:0] lo,
  output logic [HALF_W-1:0] hi
);
  logic [HALF_W-1:0] lo_q, lo_d, hi_q, hi_d;
  logic              any_wr, step;

  always_comb begin
    any_wr = lo_wr | hi_wr | rtc_wr;
    step   = run & tick_en & ~any_wr;
    lo_d   = lo_q;
    hi_d   = hi_q;
    if (step) begin
      lo_d = lo_q + 1'b1;
      if (&lo_q) hi_d = hi_q + 1'b1;
    end
    if (lo_wr)       lo_d = wdata;
    else if (rtc_wr) lo_d = wdata & RTC_MASK;
    if (hi_wr)       hi_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= lo_d;
      hi_q <= hi_d;
    end
  end

  assign lo = lo_q;
  assign hi = hi_q;
endmodule

// File: rtl/tbdec_down.sv
module tbdec_down #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_en,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         ack,
  output logic [W-1:0] count,
  output logic         irq
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         irq_q, irq_d, raise;

  always_comb begin
    cnt_d = cnt_q;
    raise = 1'b0;
    if (wr) begin
      cnt_d = wdata;
      raise = wdata[W-1] & ~cnt_q[W-1];
    end else if (tick_en) begin
      if (cnt_q == '0) begin
        cnt_d = '1;
        raise = 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
    irq_d = raise | (irq_q & ~ack);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '1;
      irq_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      irq_q <= irq_d;
    end
  end

  assign count = cnt_q;
  assign irq   = irq_q;
endmodule

// File: rtl/tbdec_unit.sv
module tbdec_unit
  import tbdec_pkg::*;
#(
  parameter int unsigned W       = WORD_W,
  parameter bit          HDEC_ON = 1'b1,
  parameter logic [W-1:0] RTC_MASK = RTC_MASK_DEF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_en,
  input  logic         tb_run,
  input  logic         tbl_wr,
  input  logic         tbu_wr,
  input  logic         rtc_wr,
  input  logic         dec_wr,
  input  logic         hdec_wr,
  input  logic [W-1:0] wr_data,
  input  logic         dec_ack,
  input  logic         hdec_ack,
  output logic [W-1:0] tb_lo,
  output logic [W-1:0] tb_hi,
  output logic [W-1:0] rtc_lo,
  output logic [W-1:0] dec_val,
  output logic [W-1:0] hdec_val,
  output logic         dec_irq,
  output logic         hdec_irq
);
  logic rst_n_i;

  tbdec_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_i)
  );

  tbdec_base #(.HALF_W(W), .RTC_MASK(RTC_MASK)) u_base (
    .clk(clk), .rst_n(rst_n_i), .tick_en(tick_en), .run(tb_run),
    .lo_wr(tbl_wr), .hi_wr(tbu_wr), .rtc_wr(rtc_wr), .wdata(wr_data),
    .lo(tb_lo), .hi(tb_hi)
  );

  assign rtc_lo = tb_lo & RTC_MASK;

  tbdec_down #(.W(W)) u_dec (
    .clk(clk), .rst_n(rst_n_i), .tick_en(tick_en), .wr(dec_wr),
    .wdata(wr_data), .ack(dec_ack), .count(dec_val), .irq(dec_irq)
  );

  generate
    if (HDEC_ON) begin : g_hdec
      tbdec_down #(.W(W)) u_hdec (
        .clk(clk), .rst_n(rst_n_i), .tick_en(tick_en), .wr(hdec_wr),
        .wdata(wr_data), .ack(hdec_ack), .count(hdec_val), .irq(hdec_irq)
      );
    end else begin : g_no_hdec
      assign hdec_val = '0;
      assign hdec_irq = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/tbdec_checker.sv
module tbdec_checker #(
  parameter int unsigned W = 32,
  parameter bit HDEC_ON = 1'b1,
  parameter logic [W-1:0] RTC_MASK = 32'h3FFF_FF80
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick_en,
  input logic         tb_run,
  input logic         tbl_wr,
  input logic         tbu_wr,
  input logic         rtc_wr,
  input logic         dec_wr,
  input logic         hdec_wr,
  input logic [W-1:0] wr_data,
  input logic         dec_ack,
  input logic         hdec_ack,
  input logic [W-1:0] tb_lo,
  input logic [W-1:0] tb_hi,
  input logic [W-1:0] rtc_lo,
  input logic [W-1:0] dec_val,
  input logic [W-1:0] hdec_val,
  input logic         dec_irq,
  input logic         hdec_irq
);
  assert_tb_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tb_run && !tbl_wr && !tbu_wr && !rtc_wr) |=> ($stable(tb_lo) && $stable(tb_hi)));

  assert_lo_wr_keeps_hi_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tbl_wr && !tbu_wr) |=> $stable(tb_hi));

  assert_hi_wr_keeps_lo_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tbu_wr && !tbl_wr && !rtc_wr) |=> $stable(tb_lo));

  assert_dec_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !dec_wr && dec_val != '0) |=> (dec_val == $past(dec_val) - 1'b1));

  assert_dec_expiry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !dec_wr && dec_val == '0) |=> (dec_irq && (&dec_val)));

  assert_dec_neg_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_wr && wr_data[W-1] && !dec_val[W-1]) |=> dec_irq);

  assert_dec_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_irq && !dec_ack) |=> dec_irq);

  assert_rtc_write_masked_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rtc_wr && !tbl_wr) |=> ((tb_lo & ~RTC_MASK) == '0));

  generate
    if (HDEC_ON) begin : g_hchk
      assert_hdec_expiry_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !hdec_wr && hdec_val == '0) |=> (hdec_irq && (&hdec_val)));
    end
  endgenerate
endmodule

bind tbdec_unit tbdec_checker #(.W(W), .HDEC_ON(HDEC_ON), .RTC_MASK(RTC_MASK)) u_chk (.*);

// File: tb/tbdec_unit_bench.sv
module tbdec_unit_bench;
  localparam time CLK_PERIOD = 10ns;
  localparam logic [31:0] MASK = 32'h3FFF_FF80;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_en = 0, tb_run = 0, tbl_wr = 0, tbu_wr = 0, rtc_wr = 0;
  logic dec_wr = 0, hdec_wr = 0, dec_ack = 0, hdec_ack = 0;
  logic [31:0] wr_data = '0;
  logic [31:0] tb_lo, tb_hi, rtc_lo, dec_val, hdec_val;
  logic dec_irq, hdec_irq;

  int checks = 0, fails = 0;

  logic [63:0] m_tb;
  logic [31:0] m_dec, m_hdec;
  logic        m_di, m_hi;

  always #(CLK_PERIOD/2) clk = ~clk;

  tbdec_unit u_tbdec_unit (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .tb_run(tb_run),
    .tbl_wr(tbl_wr), .tbu_wr(tbu_wr), .rtc_wr(rtc_wr), .dec_wr(dec_wr),
    .hdec_wr(hdec_wr), .wr_data(wr_data), .dec_ack(dec_ack), .hdec_ack(hdec_ack),
    .tb_lo(tb_lo), .tb_hi(tb_hi), .rtc_lo(rtc_lo), .dec_val(dec_val),
    .hdec_val(hdec_val), .dec_irq(dec_irq), .hdec_irq(hdec_irq)
  );

  task automatic model_down(inout logic [31:0] c, inout logic q,
                            input logic wr, input logic ack);
    logic up;
    up = 1'b0;
    if (wr) begin
      up = wr_data[31] && !c[31];
      c  = wr_data;
    end else if (tick_en) begin
      if (c == 0) begin c = 32'hFFFF_FFFF; up = 1'b1; end
      else c = c - 1;
    end
    q = up ? 1'b1 : (ack ? 1'b0 : q);
  endtask

  always @(posedge clk or negedge rst_n) begin : model
    logic [63:0] t;
    logic [31:0] d, h;
    logic di, hi;
    if (!rst_n) begin
      m_tb <= '0; m_dec <= '1; m_hdec <= '1; m_di <= 0; m_hi <= 0;
    end else begin
      t = m_tb;
      if (tb_run && tick_en && !(tbl_wr || tbu_wr || rtc_wr)) t = t + 1;
      if (tbl_wr) t[31:0] = wr_data;
      else if (rtc_wr) t[31:0] = wr_data & MASK;
      if (tbu_wr) t[63:32] = wr_data;
      d = m_dec; di = m_di; h = m_hdec; hi = m_hi;
      model_down(d, di, dec_wr, dec_ack);
      model_down(h, hi, hdec_wr, hdec_ack);
      m_tb <= t; m_dec <= d; m_di <= di; m_hdec <= h; m_hi <= hi;
    end
  end

  task automatic chk(input bit ok, input string tag,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cmp_model();
    chk({tb_hi, tb_lo} == m_tb, "R2 time base vs model", {tb_hi, tb_lo}, m_tb);
    chk(dec_val == m_dec, "R5 dec vs model", dec_val, m_dec);
    chk(hdec_val == m_hdec, "R10 hdec vs model", hdec_val, m_hdec);
    chk(dec_irq == m_di, "R9 dec_irq vs model", dec_irq, m_di);
    chk(hdec_irq == m_hi, "R10 hdec_irq vs model", hdec_irq, m_hi);
    chk(rtc_lo == (m_tb[31:0] & MASK), "R11 rtc view vs model", rtc_lo, m_tb[31:0] & MASK);
  endtask

  task automatic cyc(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      cmp_model();
    end
  endtask

  task automatic idle_strobes();
    tbl_wr = 0; tbu_wr = 0; rtc_wr = 0; dec_wr = 0; hdec_wr = 0;
    dec_ack = 0; hdec_ack = 0;
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 100000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cyc(3);
    // R1 reset state
    chk({tb_hi, tb_lo} == 64'd0, "R1 tb reset", {tb_hi, tb_lo}, 0);
    chk(dec_val == 32'hFFFF_FFFF && hdec_val == 32'hFFFF_FFFF, "R1 dec reset",
        {dec_val, hdec_val}, 64'hFFFF_FFFF_FFFF_FFFF);
    chk(!dec_irq && !hdec_irq, "R1 irq reset", {dec_irq, hdec_irq}, 0);

    // R2 / R5 counting
    tb_run = 1; tick_en = 1;
    cyc(5);
    chk({tb_hi, tb_lo} == 64'd5, "R2 count 5", {tb_hi, tb_lo}, 5);
    chk(dec_val == 32'hFFFF_FFFA, "R5 dec down 5", dec_val, 32'hFFFF_FFFA);

    // R4 lower write suppresses increment, then R2 carry
    tbl_wr = 1; wr_data = 32'hFFFF_FFFF; cyc(); tbl_wr = 0;
    chk({tb_hi, tb_lo} == 64'h0000_0000_FFFF_FFFF, "R4 lower write", {tb_hi, tb_lo},
        64'h0000_0000_FFFF_FFFF);
    cyc();
    chk({tb_hi, tb_lo} == 64'h1_0000_0000, "R2 carry", {tb_hi, tb_lo}, 64'h1_0000_0000);

    // R3 freeze and resume; R5 dec keeps counting
    tb_run = 0; cyc(4);
    chk({tb_hi, tb_lo} == 64'h1_0000_0000, "R3 frozen", {tb_hi, tb_lo}, 64'h1_0000_0000);
    chk(dec_val == 32'hFFFF_FFF4, "R5 dec runs while frozen", dec_val, 32'hFFFF_FFF4);
    tb_run = 1; cyc();
    chk({tb_hi, tb_lo} == 64'h1_0000_0001, "R3 resume", {tb_hi, tb_lo}, 64'h1_0000_0001);

    // R4 upper write keeps lower
    tbu_wr = 1; wr_data = 32'h1234_5678; cyc(); tbu_wr = 0;
    chk({tb_hi, tb_lo} == 64'h1234_5678_0000_0001, "R4 upper write", {tb_hi, tb_lo},
        64'h1234_5678_0000_0001);

    // R7 positive over negative: no irq; R6 expiry
    tick_en = 0; dec_wr = 1; wr_data = 32'd3; cyc(); dec_wr = 0;
    chk(!dec_irq && dec_val == 3, "R7 positive write no irq", {dec_irq, dec_val}, 3);
    tick_en = 1; cyc(3);
    chk(dec_val == 0 && !dec_irq, "R6 at zero no irq yet", {dec_irq, dec_val}, 0);
    cyc();
    chk(dec_val == 32'hFFFF_FFFF && dec_irq, "R6 expiry wrap+irq", {dec_irq, dec_val},
        {1'b1, 32'hFFFF_FFFF});

    // R9 sticky then ack
    tick_en = 0; cyc(3);
    chk(dec_irq, "R9 sticky", dec_irq, 1);
    dec_ack = 1; cyc(); dec_ack = 0;
    chk(!dec_irq, "R9 ack clears", dec_irq, 0);

    // R7 negative over positive raises, negative over negative does not
    dec_wr = 1; wr_data = 32'd5; cyc();
    wr_data = 32'h8000_0000; cyc(); dec_wr = 0;
    chk(dec_irq, "R7 neg over pos raises", dec_irq, 1);
    dec_ack = 1; cyc(); dec_ack = 0;
    dec_wr = 1; wr_data = 32'h8000_0001; cyc(); dec_wr = 0;
    chk(!dec_irq && dec_val == 32'h8000_0001, "R7 neg over neg silent",
        {dec_irq, dec_val}, 32'h8000_0001);

    // R8 write beats expiry
    dec_wr = 1; wr_data = 32'd0; cyc();
    tick_en = 1; wr_data = 32'd7; cyc(); dec_wr = 0; tick_en = 0;
    chk(dec_val == 7 && !dec_irq, "R8 write over expiry", {dec_irq, dec_val}, 7);

    // R9 raise beats ack
    dec_wr = 1; wr_data = 32'd0; cyc(); dec_wr = 0;
    tick_en = 1; dec_ack = 1; cyc(); dec_ack = 0; tick_en = 0;
    chk(dec_irq, "R9 raise wins over ack", dec_irq, 1);
    dec_ack = 1; cyc(); dec_ack = 0;

    // R10 hypervisor decrementer independent
    hdec_wr = 1; wr_data = 32'h8000_0000; cyc();
    chk(!hdec_irq, "R10 hdec neg over neg silent", hdec_irq, 0);
    wr_data = 32'd1; cyc(); hdec_wr = 0;
    tick_en = 1; cyc(2); tick_en = 0;
    chk(hdec_irq && hdec_val == 32'hFFFF_FFFF, "R10 hdec expiry", {hdec_irq, hdec_val},
        {1'b1, 32'hFFFF_FFFF});
    chk(!dec_irq, "R10 dec unaffected", dec_irq, 0);
    hdec_ack = 1; cyc(); hdec_ack = 0;
    chk(!hdec_irq, "R10 hdec ack", hdec_irq, 0);

    // R11 masked view
    rtc_wr = 1; wr_data = 32'hFFFF_FFFF; cyc(); rtc_wr = 0;
    chk(tb_lo == 32'h3FFF_FF80 && rtc_lo == 32'h3FFF_FF80, "R11 rtc write",
        {tb_lo, rtc_lo}, {32'h3FFF_FF80, 32'h3FFF_FF80});
    chk(tb_hi == 32'h1234_5678, "R11 rtc write keeps upper", tb_hi, 32'h1234_5678);
    tick_en = 1; cyc(); tick_en = 0;
    chk(tb_lo == 32'h3FFF_FF81 && rtc_lo == 32'h3FFF_FF80, "R11 low bits hidden",
        {tb_lo, rtc_lo}, {32'h3FFF_FF81, 32'h3FFF_FF80});
    tbl_wr = 1; rtc_wr = 1; wr_data = 32'h0000_007F; cyc(); idle_strobes();
    chk(tb_lo == 32'h0000_007F && rtc_lo == 0, "R11 tbl_wr wins", {tb_lo, rtc_lo},
        {32'h0000_007F, 32'h0});

    // random phase with per-cycle model comparison
    for (int k = 0; k < 3000; k++) begin
      tick_en  = ($urandom % 4) != 0;
      tb_run   = ($urandom % 10) != 0;
      tbl_wr   = ($urandom % 40) == 0;
      tbu_wr   = ($urandom % 40) == 0;
      rtc_wr   = ($urandom % 40) == 0;
      dec_wr   = ($urandom % 12) == 0;
      hdec_wr  = ($urandom % 12) == 0;
      dec_ack  = ($urandom % 8) == 0;
      hdec_ack = ($urandom % 8) == 0;
      wr_data  = (($urandom % 3) != 0) ? ($urandom % 6) : $urandom;
      cyc();
    end
    idle_strobes();
    cyc();

    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule